// File: doc/BRIEF.md
# Random Memory Tag Generator

The block picks a 4-bit allocation tag for a 64-bit pointer and writes that tag into the pointer's tag field. It has two operations. In generate mode a 16-bit seed taken from a state register drives a linear feedback shift register (LFSR). Four LFSR steps give a random step count. Starting from the tag held in the state register, the block then walks through the tag values that are not excluded. The exclusion set is a 16-bit mask with one bit per tag value. When the walk ends, the new tag and the advanced seed are returned as an updated state word, ready to be written back.

In add mode the block adds a signed offset to the pointer. It then moves the pointer's existing tag forward by a given step count, skipping excluded values in the same way.

A request is accepted only while the block is idle. The walk advances one tag value per clock. A single-cycle `done` strobe marks the point at which the results are valid, and the results stay on the outputs until the next request is accepted.

Top module: `memTagGen`

## Requirements
- R1: In generate mode, tag value t is excluded when bit t of (`excludeOperand` OR `ctrlReg[15:0]`) is set.
- R2: In generate mode, the start tag is `stateIn[3:0]` and the seed is `stateIn[23:8]`.
- R3: A generation applies four LFSR steps to the seed. Each step computes f = s[5]^s[3]^s[2]^s[0], shifts the seed right by one bit, and puts f in bit 15. The feedback of step k (k = 0..3) becomes bit k of the step count.
- R4: If all 16 exclusion bits are set, the result tag is 0, whatever the start tag and the step count.
- R5: Tag selection first advances the start tag (modulo 16) while it is excluded. It then moves to the next non-excluded value once per remaining step.
- R6: If the seed is zero and `ctrlReg[16]` (random mode) is set, the seed 0xACE1 is used in its place before stepping. A zero seed with `ctrlReg[16]` clear stays zero and gives a step count of 0.
- R7: After a generation, `stateOut` carries the new tag in bits 3:0 and the new seed in bits 23:8, with bits 7:4 zero. `stateWe` is high only during the `done` cycle of a generation.
- R8: In add mode, the result pointer is `ptrIn + addOffset`. The start tag is `ptrIn[59:56]`, the step count is `tagStep`, only `ctrlReg[15:0]` excludes, `excludeOperand` is ignored, and `stateWe` stays low.
- R9: The chosen tag replaces pointer bits 59:56. All other bits of the (generate: input, add: summed) pointer pass through unchanged.
- R10: `done` is high for exactly one cycle per accepted request, and the latency from acceptance to `done` is at most 16×17+2 cycles. `startReq` has no effect while `busy` is high, and that includes the `done` cycle.
- R11: During and right after reset, `busy`, `done` and `stateWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request pulse, accepted only when idle |
| opAdd | input | 1 | 0 = generate mode, 1 = add mode |
| ptrIn | input | 64 | Source pointer |
| excludeOperand | input | 16 | Extra exclusion bits (generate mode only) |
| ctrlReg | input | 17 | [15:0] base exclusion mask, [16] random mode |
| stateIn | input | 24 | [3:0] start tag, [23:8] seed |
| addOffset | input | 64 | Signed offset added in add mode |
| tagStep | input | 4 | Step count in add mode |
| busy | output | 1 | Request in progress (includes the done cycle) |
| done | output | 1 | Single-cycle strobe: results are valid |
| ptrOut | output | 64 | Pointer with the new tag |
| stateOut | output | 24 | Updated state word |
| stateWe | output | 1 | State write-back strobe (generate mode) |

## Verification
A second request can coincide with the cycle in which the first one completes. The bench provokes this in two ways: it raises `startReq` in the middle of a walk, and again exactly in the `done` cycle, each time with different operands. It then judges the outcome at the ports. The results of the first request must remain on the outputs, the two extra pulses must not produce a second `done`, and `busy` must not rise again. Generating the seed and starting the walk also share the load cycle, most visibly when a zero seed is replaced. That case is judged by comparing the step count and the written-back seed with values computed from R3 and R6.

// File: rtl/memTagGenPkg.sv
package memTagGenPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic consume;
    logic forceZero;
  } ctrlStb_t;

  // status from datapath to control
  typedef struct packed {
    logic curExcluded;
    logic allExcluded;
    logic stepsZero;
  } dpStat_t;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'd0,
    FSM_SEEK = 2'd1,
    FSM_DONE = 2'd2
  } fsm_t;

endpackage

// File: rtl/memTagGenCtrl.sv
module memTagGenCtrl
  import memTagGenPkg::*;
#(
  parameter int unsigned TAG_W = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  dpStat_t  stat,
  output ctrlStb_t stb,
  output logic     busy,
  output logic     done
);

  localparam int unsigned TAG_VALUES = 1 << TAG_W;
  localparam int unsigned SEEK_LIMIT = TAG_VALUES * (TAG_VALUES + 1);
  localparam int unsigned CNT_W      = $clog2(SEEK_LIMIT + 2);

  fsm_t             state, stateNext;
  logic [CNT_W-1:0] seekCnt;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      FSM_IDLE: begin
        if (startReq) begin
          stb.load  = 1'b1;
          stateNext = FSM_SEEK;
        end
      end
      FSM_SEEK: begin
        if (stat.allExcluded) begin
          stb.forceZero = 1'b1;
          stateNext     = FSM_DONE;
        end else if (stat.curExcluded) begin
          stb.advance = 1'b1;
        end else if (stat.stepsZero) begin
          stateNext = FSM_DONE;
        end else begin
          stb.advance = 1'b1;
          stb.consume = 1'b1;
        end
      end
      FSM_DONE: stateNext = FSM_IDLE;
      default:  stateNext = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= FSM_IDLE;
      seekCnt <= '0;
    end else begin
      state <= stateNext;
      if (stb.load)
        seekCnt <= '0;
      else if (state == FSM_SEEK)
        seekCnt <= seekCnt + 1'b1;
    end
  end

  assign busy = (state != FSM_IDLE);
  assign done = (state == FSM_DONE);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  seek_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    seekCnt <= CNT_W'(SEEK_LIMIT));

endmodule

// File: rtl/memTagGenDp.sv
module memTagGenDp
  import memTagGenPkg::*;
#(
  parameter int unsigned PTR_W    = 64,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned TAG_LSB  = 56,
  parameter int unsigned SEED_W   = 16,
  parameter int unsigned SEED_LSB = 8,
  parameter logic [15:0] SUB_SEED = 16'hACE1,
  localparam int unsigned MASK_W  = 1 << TAG_W,
  localparam int unsigned CTRL_W  = MASK_W + 1,
  localparam int unsigned STATE_W = SEED_LSB + SEED_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic               opAdd,
  input  logic [PTR_W-1:0]   ptrIn,
  input  logic [MASK_W-1:0]  excludeOperand,
  input  logic [CTRL_W-1:0]  ctrlReg,
  input  logic [STATE_W-1:0] stateIn,
  input  logic [PTR_W-1:0]   addOffset,
  input  logic [TAG_W-1:0]   tagStep,
  output dpStat_t            stat,
  output logic               opAddQ,
  output logic [PTR_W-1:0]   ptrOut,
  output logic [STATE_W-1:0] stateOut
);

  localparam int unsigned RND_BIT = MASK_W;

  logic [MASK_W-1:0] maskReg;
  logic [TAG_W-1:0]  curTag;
  logic [TAG_W-1:0]  stepsLeft;
  logic [SEED_W-1:0] seedReg;
  logic [PTR_W-1:0]  ptrBase;

  logic [SEED_W-1:0] rawSeed, useSeed;
  logic [TAG_W-1:0]  lfsrOff;
  logic [TAG_W:0][SEED_W-1:0] seedChain;
  logic              unusedStateBits;

  assign unusedStateBits = ^stateIn[SEED_LSB-1:TAG_W];

  assign rawSeed = stateIn[SEED_LSB +: SEED_W];
  assign useSeed = ((rawSeed == '0) && ctrlReg[RND_BIT]) ? SEED_W'(SUB_SEED) : rawSeed;
  assign seedChain[0] = useSeed;

  // one unrolled LFSR stage per step-count bit
  for (genvar g = 0; g < TAG_W; g++) begin : gLfsr
    logic fb;
    assign fb = seedChain[g][5] ^ seedChain[g][3] ^ seedChain[g][2] ^ seedChain[g][0];
    assign seedChain[g+1] = {fb, seedChain[g][SEED_W-1:1]};
    assign lfsrOff[g] = fb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      curTag    <= '0;
      stepsLeft <= '0;
      seedReg   <= '0;
      ptrBase   <= '0;
      opAddQ    <= 1'b0;
    end else if (stb.load) begin
      opAddQ <= opAdd;
      if (opAdd) begin
        maskReg   <= ctrlReg[MASK_W-1:0];
        curTag    <= ptrIn[TAG_LSB +: TAG_W];
        stepsLeft <= tagStep;
        ptrBase   <= ptrIn + addOffset;
      end else begin
        maskReg   <= excludeOperand | ctrlReg[MASK_W-1:0];
        curTag    <= stateIn[TAG_W-1:0];
        stepsLeft <= lfsrOff;
        seedReg   <= seedChain[TAG_W];
        ptrBase   <= ptrIn;
      end
    end else begin
      if (stb.forceZero)
        curTag <= '0;
      else if (stb.advance)
        curTag <= curTag + 1'b1;
      if (stb.consume)
        stepsLeft <= stepsLeft - 1'b1;
    end
  end

  assign stat.curExcluded = maskReg[curTag];
  assign stat.allExcluded = &maskReg;
  assign stat.stepsZero   = (stepsLeft == '0);

  always_comb begin
    ptrOut = ptrBase;
    ptrOut[TAG_LSB +: TAG_W] = curTag;
  end

  always_comb begin
    stateOut = '0;
    stateOut[TAG_W-1:0] = curTag;
    stateOut[SEED_LSB +: SEED_W] = seedReg;
  end

  // R6
  seed_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !opAdd && ctrlReg[RND_BIT]) |=> (seedReg != '0));

  // R5
  steps_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> (stepsLeft <= $past(stepsLeft)));

endmodule

// File: rtl/memTagGen.sv
module memTagGen
  import memTagGenPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        opAdd,
  input  logic [63:0] ptrIn,
  input  logic [15:0] excludeOperand,
  input  logic [16:0] ctrlReg,
  input  logic [23:0] stateIn,
  input  logic [63:0] addOffset,
  input  logic [3:0]  tagStep,
  output logic        busy,
  output logic        done,
  output logic [63:0] ptrOut,
  output logic [23:0] stateOut,
  output logic        stateWe
);

  localparam int unsigned PTR_W   = 64;
  localparam int unsigned TAG_W   = 4;
  localparam int unsigned TAG_LSB = 56;

  ctrlStb_t stb;
  dpStat_t  stat;
  logic     opAddQ;

  memTagGenCtrl #(.TAG_W(TAG_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stat     (stat),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  memTagGenDp #(
    .PTR_W    (PTR_W),
    .TAG_W    (TAG_W),
    .TAG_LSB  (TAG_LSB),
    .SEED_W   (16),
    .SEED_LSB (8),
    .SUB_SEED (16'hACE1)
  ) uDp (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .opAdd          (opAdd),
    .ptrIn          (ptrIn),
    .excludeOperand (excludeOperand),
    .ctrlReg        (ctrlReg),
    .stateIn        (stateIn),
    .addOffset      (addOffset),
    .tagStep        (tagStep),
    .stat           (stat),
    .opAddQ         (opAddQ),
    .ptrOut         (ptrOut),
    .stateOut       (stateOut)
  );

  assign stateWe = done && !opAddQ;

  // R5
  result_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !stat.allExcluded) |-> !stat.curExcluded);

  // R4
  all_excluded_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && stat.allExcluded) |-> (ptrOut[TAG_LSB +: TAG_W] == '0));

endmodule

// File: tb/memTagGen_test.sv
module memTagGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        opAdd = 1'b0;
  logic [63:0] ptrIn = '0;
  logic [15:0] excludeOperand = '0;
  logic [16:0] ctrlReg = '0;
  logic [23:0] stateIn = '0;
  logic [63:0] addOffset = '0;
  logic [3:0]  tagStep = '0;
  logic        busy, done, stateWe;
  logic [63:0] ptrOut;
  logic [23:0] stateOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  memTagGen uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opAdd(opAdd), .ptrIn(ptrIn),
    .excludeOperand(excludeOperand), .ctrlReg(ctrlReg), .stateIn(stateIn),
    .addOffset(addOffset), .tagStep(tagStep), .busy(busy), .done(done),
    .ptrOut(ptrOut), .stateOut(stateOut), .stateWe(stateWe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---- expected-value model built from the requirements ----
  function automatic logic [3:0] pickTag(input logic [3:0] start, input logic [3:0] steps, input logic [15:0] mask);
    logic [3:0] t = start;
    if (mask == 16'hFFFF) return 4'd0;
    while (mask[t]) t = t + 4'd1;
    for (int i = 0; i < steps; i++) begin
      t = t + 4'd1;
      while (mask[t]) t = t + 4'd1;
    end
    return t;
  endfunction

  task automatic lfsrModel(input logic [15:0] s0, output logic [15:0] s, output logic [3:0] off);
    logic f;
    s = s0;
    off = '0;
    for (int k = 0; k < 4; k++) begin
      f = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {f, s[15:1]};
      off[k] = f;
    end
  endtask

  task automatic expGen(input logic [63:0] p, input logic [15:0] op, input logic [16:0] c,
                        input logic [23:0] s, output logic [63:0] ep, output logic [23:0] es);
    logic [15:0] seed, ns;
    logic [3:0]  off, t;
    seed = s[23:8];
    if (seed == 16'h0 && c[16]) seed = 16'hACE1;
    lfsrModel(seed, ns, off);
    t = pickTag(s[3:0], off, op | c[15:0]);
    ep = p;
    ep[59:56] = t;
    es = {ns, 4'h0, t};
  endtask

  function automatic logic [63:0] expAdd(input logic [63:0] p, input logic [63:0] off,
                                         input logic [15:0] c, input logic [3:0] st);
    logic [63:0] r = p + off;
    r[59:56] = pickTag(p[59:56], st, c);
    return r;
  endfunction

  task automatic runOp(input logic add, input logic [63:0] p, input logic [15:0] op,
                       input logic [16:0] c, input logic [23:0] s, input logic [63:0] off,
                       input logic [3:0] st, output logic [63:0] gp, output logic [23:0] gs,
                       output logic gw, output int lat);
    @(negedge clk);
    opAdd = add; ptrIn = p; excludeOperand = op; ctrlReg = c; stateIn = s;
    addOffset = off; tagStep = st; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R10 done never rose", 64'(done), 64'd1);
    gp = ptrOut; gs = stateOut; gw = stateWe;
  endtask

  // ---- scenarios ----
  task automatic testReset();
    check(!busy, "R11 busy after reset", 64'(busy), 0);
    check(!done, "R11 done after reset", 64'(done), 0);
    check(!stateWe, "R11 stateWe after reset", 64'(stateWe), 0);
  endtask

  task automatic testGenPatterns();
    logic [63:0] p, gp, ep;
    logic [23:0] s, gs, es;
    logic [16:0] c;
    logic [15:0] op;
    logic gw;
    int lat;
    for (int i = 0; i < 6; i++) begin
      p  = 64'hF5A5_3C3C_9696_0F0F ^ (64'(i) * 64'h0123_4567_89AB_CDEF);
      s  = {16'(16'h1D2B * (i + 1)), 4'h0, 4'(i * 5)};
      c  = {1'b0, 16'(16'h0101 << i)};
      op = 16'(16'h8000 >> i);
      runOp(1'b0, p, op, c, s, '0, '0, gp, gs, gw, lat);
      expGen(p, op, c, s, ep, es);
      check(gp == ep, "R5 R3 R2 generated pointer", gp, ep);
      check(gs == es, "R7 R3 written-back state", 64'(gs), 64'(es));
      check(gw, "R7 stateWe in generate done cycle", 64'(gw), 1);
      check((gp & ~64'h0F00_0000_0000_0000) == (p & ~64'h0F00_0000_0000_0000),
            "R9 untouched pointer bits", gp, p);
    end
  endtask

  task automatic testMaskOr();
    logic [63:0] gp;
    logic [23:0] gs;
    logic gw;
    int lat;
    // zero seed, random bit clear: step count 0
    runOp(1'b0, 64'h0, 16'h0008, 17'h0, 24'h000003, '0, '0, gp, gs, gw, lat);
    check(gp[59:56] == 4'd4, "R1 operand mask excludes tag 3", 64'(gp[59:56]), 4);
    check(gs == 24'h000004, "R6 zero seed kept with random bit clear", 64'(gs), 64'h4);
    runOp(1'b0, 64'h0, 16'h0008, 17'h0010, 24'h000003, '0, '0, gp, gs, gw, lat);
    check(gp[59:56] == 4'd5, "R1 OR of operand and control masks", 64'(gp[59:56]), 5);
    runOp(1'b0, 64'h0, 16'h0000, 17'h0001, 24'h00000F, '0, '0, gp, gs, gw, lat);
    check(gp[59:56] == 4'd15, "R2 start tag from state bits 3:0", 64'(gp[59:56]), 15);
  endtask

  task automatic testAllExcluded();
    logic [63:0] gp, ep;
    logic [23:0] gs, es;
    logic gw;
    int lat;
    runOp(1'b0, 64'h1234_5678_9ABC_DEF0, 16'hFF00, 17'h000FF, 24'h77770A, '0, '0, gp, gs, gw, lat);
    expGen(64'h1234_5678_9ABC_DEF0, 16'hFF00, 17'h000FF, 24'h77770A, ep, es);
    check(gp[59:56] == 4'd0, "R4 all excluded gives tag 0", 64'(gp[59:56]), 0);
    check(gs == es, "R4 seed still advances when all excluded", 64'(gs), 64'(es));
  endtask

  task automatic testSeedSub();
    logic [63:0] gp, ep;
    logic [23:0] gs, es;
    logic gw;
    int lat;
    runOp(1'b0, 64'hAAAA_0000_5555_0000, 16'h0000, 17'h10000, 24'h000006, '0, '0, gp, gs, gw, lat);
    expGen(64'hAAAA_0000_5555_0000, 16'h0000, 17'h10000, 24'h000006, ep, es);
    check(gs[23:8] != 16'h0, "R6 substituted seed is non-zero", 64'(gs[23:8]), 64'(es[23:8]));
    check(gs == es, "R6 substituted seed drives step count", 64'(gs), 64'(es));
    check(gp == ep, "R6 R3 pointer after substitution", gp, ep);
  endtask

  task automatic testAddMode();
    logic [63:0] gp, ep;
    logic [23:0] gs;
    logic gw;
    int lat;
    runOp(1'b1, 64'h0A00_0000_0000_1000, 16'hFFFF, 17'h10800, 24'h0, 64'hFFFF_FFFF_FFFF_FFF0,
          4'd1, gp, gs, gw, lat);
    ep = 64'h0C00_0000_0000_0FF0;
    check(gp == ep, "R8 add mode offset, step, control-only mask", gp, ep);
    check(!gw, "R8 no state write in add mode", 64'(gw), 0);
    runOp(1'b1, 64'h00FF_FFFF_FFFF_FFFF, 16'h0, 17'h0, 24'h0, 64'h1, 4'd0, gp, gs, gw, lat);
    check(gp == 64'h0, "R9 carry into tag field is replaced", gp, 64'h0);
    runOp(1'b1, 64'h7300_1111_2222_3333, 16'h0, 17'h0_0F0F, 24'h0, 64'h40, 4'd3, gp, gs, gw, lat);
    ep = expAdd(64'h7300_1111_2222_3333, 64'h40, 16'h0F0F, 4'd3);
    check(gp == ep, "R8 add mode skip over excluded run", gp, ep);
  endtask

  task automatic testWorstLatency();
    logic [63:0] gp;
    logic [23:0] gs;
    logic gw;
    int lat;
    runOp(1'b1, 64'h0100_0000_0000_0000, 16'h0, 17'h0FFFE, 24'h0, 64'h0, 4'd15, gp, gs, gw, lat);
    check(gp[59:56] == 4'd0, "R5 single allowed tag after 15 steps", 64'(gp[59:56]), 0);
    check(lat <= 16 * 17 + 2, "R10 latency bound", 64'(lat), 64'(16 * 17 + 2));
  endtask

  task automatic testBusyIgnore();
    logic [63:0] ep, held;
    logic [23:0] es;
    bit extraDone = 0;
    bit extraBusy = 0;
    int lat = 0;
    @(negedge clk);
    opAdd = 1'b0; ptrIn = 64'h0000_0000_DEAD_BEEF; excludeOperand = 16'h0; ctrlReg = 17'h0F0F0;
    stateIn = 24'hBEEF02; startReq = 1'b1;
    expGen(64'h0000_0000_DEAD_BEEF, 16'h0, 17'h0F0F0, 24'hBEEF02, ep, es);
    @(negedge clk);
    startReq = 1'b0;
    // second request in the middle of the walk
    ptrIn = 64'hFFFF_FFFF_FFFF_FFFF; stateIn = 24'h12340C; startReq = busy;
    @(negedge clk);
    startReq = 1'b0;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check(done, "R10 first request completes", 64'(done), 1);
    check(ptrOut == ep, "R10 request while busy ignored", ptrOut, ep);
    held = ptrOut;
    // third request exactly in the done cycle
    opAdd = 1'b1; ptrIn = 64'h5555_5555_5555_5555; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (done) extraDone = 1;
      if (busy) extraBusy = 1;
      @(negedge clk);
    end
    check(!extraDone, "R10 no second done from done-cycle request", 64'(extraDone), 0);
    check(!extraBusy, "R10 busy stays low after ignored request", 64'(extraBusy), 0);
    check(ptrOut == held, "R10 results held after ignored request", ptrOut, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGenPatterns();
    testMaskOr();
    testAllExcluded();
    testSeedSub();
    testAddMode();
    testWorstLatency();
    testBusyIgnore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule